// File: doc/BRIEF.md
# SPI Slave Front End with Hold Pause and Strap Address Match

This block is the serial front end of a small register-controlled peripheral. An external controller runs mode-0 SPI transfers. The block samples the serial input on rising SCK, drives the serial output on falling SCK, and frames every transfer with an active-low chip select. All four serial inputs pass through two-flop synchronisers into the system clock. Every SCK, chip-select and hold edge is detected in the system clock domain.

The first byte of each frame is an address byte, {4'b0101, 2'b00, strap[1], strap[0]}. When it matches, each following byte goes to the register back end with a one-cycle strobe. The byte the back end presents on `tx_byte_i` is shifted out during the next byte. When it does not match, the rest of the frame is ignored. An active-low hold input can pause a transfer without losing its position.

Top module: `spi_addr_slave`

## Requirements
- R1: SDI is captured on each rising SCK edge, MSB first. After the 8th rising edge of every byte that follows an accepted address byte, `rx_valid_o` pulses high for exactly one system clock, with the byte on `rx_byte_o`.
- R2: `tx_byte_i` is sampled at the 8th rising SCK edge of each byte in an accepted frame (the address byte included). It is shifted out MSB first during the following byte, and SDO changes only after falling SCK edges.
- R3: While no frame is active (chip select high, or after reset), `sdo_oe_o` is 0 and `frame_ok_o` is 0.
- R4: A pause starts only when hold falls while SCK is low. A hold fall while SCK is high causes no pause. A paused transfer resumes only when hold rises while SCK is low; a rise while SCK is high leaves it paused. `hold_o` shows the pause.
- R5: While paused, SCK edges are ignored. The bit count and both shift registers keep their contents, so the byte completes correctly after resume.
- R6: An address byte equal to {4'b0101, 2'b00, strap_i} accepts the frame. `frame_ok_o` then stays 1 until chip select rises.
- R7: If any bit of the address byte differs, no strobe is raised for the rest of the frame and SDO stays 0 until chip select rises.
- R8: After reset, no frame starts until a high-to-low transition of chip select has been seen. A chip select held low through reset is ignored.
- R9: A rise of chip select in the middle of a byte discards the partial byte and clears the bit count. The next frame starts from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the controller |
| sdi_i | input | 1 | Serial data in |
| csn_i | input | 1 | Chip select, active low |
| holdn_i | input | 1 | Hold pause request, active low |
| strap_i | input | 2 | Address LSB strap pins |
| tx_byte_i | input | 8 | Read data from the back end |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for SDO (pad tri-state control) |
| rx_byte_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| frame_ok_o | output | 1 | Address matched in the current frame |
| hold_o | output | 1 | Transfer paused |

## Verification
The main function is exercised with several byte patterns: alternating, single-bit and all-ones-heavy values. These show bit order and shift-register alignment, and the output stream is checked against the byte the back end presented one byte earlier. Address bytes are tried with the correct value under two strap settings, a wrong strap bit and a wrong identifier. This separates a true match from a partial compare. Hold is applied in three ways: a pause with SCK toggling inside it, a hold fall while SCK is high, and a resume attempt while SCK is high. These distinguish edge qualification from plain level gating. Frames cut off mid-byte, and a chip select held low through reset, check framing.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_ADDR = 2'd1,
    FR_DATA = 2'd2,
    FR_SKIP = 2'd3
  } frame_e;

  // Address byte the slave answers to: identifier, two zero bits, strap pins
  function automatic logic [7:0] addr_byte(input logic [3:0] id, input logic [1:0] strap);
    return {id, 2'b00, strap};
  endfunction
endpackage

// File: rtl/sas_sync.sv
module sas_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {2{RST_VAL[i]}};
      else        ff <= {ff[0], d[i]};
    end
    assign q[i] = ff[1];
  end
endmodule

// File: rtl/sas_hold.sv
module sas_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_act,
  input  logic sck_lvl,
  input  logic hold_fall,
  input  logic hold_rise,
  output logic paused
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                paused <= 1'b0;
    else if (!frame_act)                       paused <= 1'b0;
    else if (!paused && hold_fall && !sck_lvl) paused <= 1'b1;
    else if (paused && hold_rise && !sck_lvl)  paused <= 1'b0;
  end
endmodule

// File: rtl/sas_shift.sv
module sas_shift #(
  parameter int BITS  = 8,
  localparam int CW   = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            rise_ev,
  input  logic            fall_ev,
  input  logic            sdi,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  output logic [BITS-1:0] rx_word,
  output logic            byte_done,
  output logic [CW-1:0]   bit_cnt,
  output logic            sdo
);
  logic [BITS-2:0] rx_sr;
  logic [BITS-1:0] tx_sr;

  assign byte_done = rise_ev && (bit_cnt == CW'(BITS - 1));
  assign rx_word   = {rx_sr, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr <= '0; tx_sr <= '0; bit_cnt <= '0; sdo <= 1'b0;
    end else if (clr) begin
      rx_sr <= '0; tx_sr <= '0; bit_cnt <= '0; sdo <= 1'b0;
    end else begin
      if (rise_ev) begin
        rx_sr   <= rx_word[BITS-2:0];
        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
      end
      if (load) begin
        tx_sr <= load_val;
      end else if (fall_ev) begin
        sdo   <= tx_sr[BITS-1];
        tx_sr <= {tx_sr[BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave #(
  parameter int         BITS   = 8,
  parameter logic [3:0] DEV_ID = 4'b0101
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_i,
  input  logic            sdi_i,
  input  logic            csn_i,
  input  logic            holdn_i,
  input  logic [1:0]      strap_i,
  input  logic [BITS-1:0] tx_byte_i,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  output logic [BITS-1:0] rx_byte_o,
  output logic            rx_valid_o,
  output logic            frame_ok_o,
  output logic            hold_o
);
  import sas_pkg::*;
  localparam int CW = $clog2(BITS);

  // Sync order {holdn, csn, sdi, sck}; csn resets low so a select held low
  // through reset produces no falling edge.
  logic [3:0] s_q;
  logic       sck_s, sdi_s, csn_s, holdn_s;
  logic       sck_p, csn_p, holdn_p;

  sas_sync #(.W(4), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({holdn_i, csn_i, sdi_i, sck_i}), .q(s_q)
  );
  assign {holdn_s, csn_s, sdi_s, sck_s} = s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= 1'b0; csn_p <= 1'b0; holdn_p <= 1'b1;
    end else begin
      sck_p <= sck_s; csn_p <= csn_s; holdn_p <= holdn_s;
    end
  end

  // Named events for assertions
  logic sck_rise, sck_fall, cs_fall, cs_rise, hold_fall, hold_rise;
  assign sck_rise  = sck_s & ~sck_p;
  assign sck_fall  = ~sck_s & sck_p;
  assign cs_fall   = ~csn_s & csn_p;
  assign cs_rise   = csn_s & ~csn_p;
  assign hold_fall = ~holdn_s & holdn_p;
  assign hold_rise = holdn_s & ~holdn_p;

  frame_e state;
  logic   frame_act, paused, rise_ev, fall_ev, byte_done, shift_sdo, load, clr;
  logic   addr_hit;
  logic [BITS-1:0] rx_word;
  logic [CW-1:0]   bit_cnt;

  assign frame_act = (state != FR_IDLE);
  assign rise_ev   = sck_rise & frame_act & ~paused & ~cs_rise;
  assign fall_ev   = sck_fall & frame_act & ~paused & ~cs_rise;
  assign addr_hit  = (rx_word == BITS'(addr_byte(DEV_ID, strap_i)));
  assign load      = byte_done & (((state == FR_ADDR) & addr_hit) | (state == FR_DATA));
  assign clr       = (state == FR_IDLE) | cs_rise;

  sas_hold u_hold (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .sck_lvl(sck_s),
    .hold_fall(hold_fall), .hold_rise(hold_rise), .paused(paused)
  );

  sas_shift #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .sdi(sdi_s), .load(load), .load_val(tx_byte_i), .rx_word(rx_word),
    .byte_done(byte_done), .bit_cnt(bit_cnt), .sdo(shift_sdo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= FR_IDLE;
    else if (cs_rise) state <= FR_IDLE;
    else if (cs_fall) state <= FR_ADDR;
    else if (byte_done && state == FR_ADDR)
      state <= addr_hit ? FR_DATA : FR_SKIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
    end else begin
      rx_valid_o <= byte_done & (state == FR_DATA);
      if (byte_done && state == FR_DATA) rx_byte_o <= rx_word;
    end
  end

  assign sdo_o      = shift_sdo & frame_act;
  assign sdo_oe_o   = frame_act;
  assign frame_ok_o = (state == FR_DATA);
  assign hold_o     = paused;
endmodule

// File: rtl/sas_chk.sv
module sas_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_act,
  input logic          paused,
  input logic          sck_s,
  input logic          cs_rise,
  input logic          cs_fall,
  input logic [CW-1:0] bit_cnt,
  input logic          rx_valid_o,
  input logic          frame_ok_o,
  input logic          sdo_oe_o
);
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  p_strobe_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(frame_ok_o));

  p_idle_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |-> (!sdo_oe_o && !frame_ok_o));

  p_pause_entry_sck_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> !$past(sck_s));

  p_resume_sck_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(paused) && frame_act) |-> !$past(sck_s));

  p_pause_freezes_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !cs_rise) |=> $stable(bit_cnt));

  p_frame_needs_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_act) |-> $past(cs_fall));

  p_cs_rise_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (bit_cnt == '0 && !frame_act));
endmodule

bind spi_addr_slave sas_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .paused(paused),
  .sck_s(sck_s), .cs_rise(cs_rise), .cs_fall(cs_fall), .bit_cnt(bit_cnt),
  .rx_valid_o(rx_valid_o), .frame_ok_o(frame_ok_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/tb_spi_addr_slave.sv
module tb_spi_addr_slave;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, csn = 1'b0, holdn = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [7:0] tx_byte = 8'h00;
  logic sdo, sdo_oe, rx_valid, frame_ok, hold_q;
  logic [7:0] rx_byte;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  spi_addr_slave dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .csn_i(csn),
    .holdn_i(holdn), .strap_i(strap), .tx_byte_i(tx_byte), .sdo_o(sdo),
    .sdo_oe_o(sdo_oe), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
    .frame_ok_o(frame_ok), .hold_o(hold_q)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pop expected bytes as strobes appear (R1, R7, R8)
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7/R8 unexpected strobe: actual %0h expected none", rx_byte);
      end else begin
        check("R1 rx byte", {24'h0, rx_byte}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One byte as controller. mode: 0 plain, 1 pause with SCK toggles,
  // 2 hold falls while SCK high, 3 resume attempt while SCK high.
  task automatic xfer(input logic [7:0] mosi, input logic [7:0] tx_next,
                      input logic [7:0] exp_miso, input bit chk_miso,
                      input bit push, input int mode);
    logic [7:0] miso = 8'h00;
    tx_byte = tx_next;
    if (push) exp_q.push_back(mosi);
    for (int i = 7; i >= 0; i--) begin
      sdi = mosi[i];
      wait_h(H);
      miso = {miso[6:0], sdo};
      sck = 1'b1;
      wait_h(H);
      if (mode == 2 && i == 4) begin
        holdn = 1'b0;
        wait_h(H);
        check("R4 no pause when SCK high", {31'h0, hold_q}, 32'h0);
      end
      sck = 1'b0;
      if (i == 4 && mode == 1) begin
        wait_h(H); holdn = 1'b0; wait_h(H);
        check("R4 pause entered", {31'h0, hold_q}, 32'h1);
        sdi = ~sdi;
        for (int k = 0; k < 2; k++) begin
          sck = 1'b1; wait_h(H); sck = 1'b0; wait_h(H);
        end
        check("R5 still paused", {31'h0, hold_q}, 32'h1);
        holdn = 1'b1; wait_h(H);
        check("R4 resumed", {31'h0, hold_q}, 32'h0);
      end
      if (i == 4 && mode == 3) begin
        wait_h(H); holdn = 1'b0; wait_h(H);
        sck = 1'b1; wait_h(H); holdn = 1'b1; wait_h(H);
        check("R4 resume ignored SCK high", {31'h0, hold_q}, 32'h1);
        sck = 1'b0; wait_h(H); holdn = 1'b0; wait_h(H); holdn = 1'b1; wait_h(H);
        check("R4 resume SCK low", {31'h0, hold_q}, 32'h0);
      end
    end
    if (mode == 2) holdn = 1'b1;
    wait_h(H);
    if (chk_miso) check("R2 miso byte", {24'h0, miso}, {24'h0, exp_miso});
  endtask

  task automatic cs_on();
    csn = 1'b0; wait_h(H);
  endtask

  task automatic cs_off(input string tag);
    wait_h(H); csn = 1'b1; wait_h(2 * H);
    check({tag, " queue drained"}, exp_q.size(), 0);
    check("R3 oe low when deselected", {31'h0, sdo_oe}, 32'h0);
  endtask

  initial begin
    wait_h(5);
    check("R3 reset oe", {31'h0, sdo_oe}, 32'h0);
    check("R3 reset frame_ok", {31'h0, frame_ok}, 32'h0);
    check("R1 reset strobe", {31'h0, rx_valid}, 32'h0);
    rst_n = 1'b1;
    wait_h(2 * H);
    // R8: select held low through reset, no falling edge seen
    xfer(8'h52, 8'h11, 8'h00, 1'b1, 1'b0, 0);
    check("R8 no frame_ok", {31'h0, frame_ok}, 32'h0);
    xfer(8'h3C, 8'h22, 8'h00, 1'b1, 1'b0, 0);
    check("R8 oe stays low", {31'h0, sdo_oe}, 32'h0);
    cs_off("R8");

    // R6/R1/R2 accepted frame, strap 10
    cs_on();
    check("R3 oe during frame", {31'h0, sdo_oe}, 32'h1);
    xfer(8'h52, 8'hA5, 8'h00, 1'b0, 1'b0, 0);
    check("R6 frame accepted", {31'h0, frame_ok}, 32'h1);
    xfer(8'h3C, 8'h96, 8'hA5, 1'b1, 1'b1, 0);
    xfer(8'h80, 8'h01, 8'h96, 1'b1, 1'b1, 0);
    xfer(8'hEF, 8'h00, 8'h01, 1'b1, 1'b1, 0);
    cs_off("R6");

    // R7: wrong strap bit, then wrong identifier
    cs_on();
    xfer(8'h53, 8'hFF, 8'h00, 1'b0, 1'b0, 0);
    check("R7 strap mismatch", {31'h0, frame_ok}, 32'h0);
    xfer(8'h5A, 8'hFF, 8'h00, 1'b1, 1'b0, 0);
    cs_off("R7 strap");
    cs_on();
    xfer(8'h92, 8'hFF, 8'h00, 1'b0, 1'b0, 0);
    check("R7 id mismatch", {31'h0, frame_ok}, 32'h0);
    xfer(8'h77, 8'hFF, 8'h00, 1'b1, 1'b0, 0);
    cs_off("R7 id");

    // R4/R5 hold variants in an accepted frame
    cs_on();
    xfer(8'h52, 8'hC3, 8'h00, 1'b0, 1'b0, 0);
    xfer(8'h6D, 8'h5A, 8'hC3, 1'b1, 1'b1, 1);
    xfer(8'hB2, 8'h3E, 8'h5A, 1'b1, 1'b1, 2);
    xfer(8'h19, 8'h00, 8'h3E, 1'b1, 1'b1, 3);
    cs_off("R5");

    // R9: partial byte discarded, then strap 01 frame
    cs_on();
    xfer(8'h52, 8'h00, 8'h00, 1'b0, 1'b0, 0);
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; wait_h(H); sck = 1'b1; wait_h(H); sck = 1'b0;
    end
    cs_off("R9 partial");
    strap = 2'b01;
    cs_on();
    xfer(8'h51, 8'h7E, 8'h00, 1'b0, 1'b0, 0);
    check("R6 strap 01 accepted", {31'h0, frame_ok}, 32'h1);
    xfer(8'h81, 8'h00, 8'h7E, 1'b1, 1'b1, 0);
    cs_off("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule